// File: doc/BRIEF.md
# Multi-format audio serial output port

This block turns received stereo audio words into a three-wire serial stream (bit clock, frame sync, data) while acting as the clock master. It runs from a master clock at 256 times the sample rate. A 4-bit mode input selects the framing: left-justified, I2S, word-sync pulse, 16-bit or 18-bit LSB-justified, or LSB-first. The same input can also put the port in an idle reset state.

Each channel word arrives with an error flag, a validity bit and a shared lock indication. In the normal modes a channel whose word is damaged, or that arrives while lock is absent, repeats the last good word of that same channel. Two pass-through modes send the damaged word as received. The block also places per-channel channel-status (C), user (U) and block-start (CBL) bits, plus error and validity-plus-error flags, on side outputs. Their timing is fixed relative to the frame sync.

Upstream logic holds the inputs for a stereo frame. The port takes all of them in one capture per frame and starts sending them at the next frame boundary.

Top module: `audio_serial_port`

## Requirements
- R1: With the port active, the master clock is split into 256-cycle frames of 64 slots, each slot 4 cycles long. sckO is low for the first two cycles of a slot and high for the last two. sdataO changes only on the first cycle of a slot, which is the falling sckO edge. Slots 0–31 carry the left channel and slots 32–63 the right; the bit slot b counts 0–31 within each channel.
- R2: Modes 0 and 8 (left-justified): fsyncO is high during the left slots and low during the right. Word bit 23 goes out at b=0, down to bit 0 at b=23, and b=24–31 are driven low.
- R3: Modes 2 and 10 (I2S): fsyncO is low for slots 0–31 and high for slots 32–63. Each channel's word is delayed by one slot: bit 23 at b=1 through bit 0 at b=24, with all other slots low.
- R4: Mode 4 (word sync): fsyncO is high only during b=0 of each channel. Data is placed as in R2.
- R5: Mode 5 sends word bits 23..8 in b=16..31, and mode 6 sends word bits 23..6 in b=14..31. In both modes the LSB is in b=31, the leading slots are low, and fsyncO is as in R2.
- R6: Mode 7 sends the word LSB first: bit 0 at b=8 up to bit 23 at b=31, leading slots low, fsyncO as in R2.
- R7: All word, flag and side inputs are captured once per frame, at the start of slot 63. They drive the outputs from the next slot 0 onward. Input changes at any other time do not affect the frame being sent.
- R8: In modes 0–7, a channel counts as bad when its error flag is high or lockOk is low. A bad channel sends the last good word captured for that channel. That stored word is zero after reset or after any inactive period.
- R9: In modes 8 and 10, a bad channel's word is sent unchanged.
- R10: erfO shows the bad state (error or no lock) of the channel being sent. verfO shows bad OR validity bit. Both change only at b=0 of a channel.
- R11: cO, uO and cblO carry the C, U and CBL bits of a channel. In non-I2S modes they switch one slot before that channel's first slot (left from slot 63, right from slot 31). In I2S modes they switch at slot 0 and slot 32.
- R12: Modes 1, 3, 9 and 11–15, and reset, make the port inactive. While inactive, all outputs are low and the frame counter is held at slot 0, so the port restarts at slot 0 when an active mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 x sample rate |
| rstN | input | 1 | Synchronous active-low reset |
| mode | input | 4 | Format and repeat selection |
| wordL | input | WORD_W | Left channel audio word |
| wordR | input | WORD_W | Right channel audio word |
| errL | input | 1 | Left word received with an error |
| errR | input | 1 | Right word received with an error |
| lockOk | input | 1 | Receiver lock present |
| validL | input | 1 | Left validity bit (1 = unreliable) |
| validR | input | 1 | Right validity bit |
| cL | input | 1 | Left channel-status bit |
| cR | input | 1 | Right channel-status bit |
| uL | input | 1 | Left user bit |
| uR | input | 1 | Right user bit |
| cblIn | input | 1 | Channel-status block-start bit for the frame |
| sckO | output | 1 | Serial bit clock |
| fsyncO | output | 1 | Frame / word sync |
| sdataO | output | 1 | Serial audio data |
| cO | output | 1 | Channel-status bit out |
| uO | output | 1 | User bit out |
| cblO | output | 1 | Block-start bit out |
| erfO | output | 1 | Error flag for the channel being sent |
| verfO | output | 1 | Validity OR error flag |

## Verification
The hardest case to reach from the ports is a repeat across a run of bad frames. There the word sent must come from a capture several frames back, and it must remain zero if no good word has arrived since the port last went idle. The stimulus sends clean frames first, then switches to frames in which per-channel errors and lock loss are drawn at random. It does this in every mode, after passing through an idle mode, so the stored word restarts from zero each time. The inputs change in the middle of each frame, which exposes any early capture. Comparing every cycle also covers the slot-63 handoff of the side bits, where the upcoming channel's value must appear before the frame boundary.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int SLOT_W   = 6;            // 64 slots per stereo frame
  localparam int BIT_W    = SLOT_W - 1;   // bit slot within a channel
  localparam int CH_SLOTS = 1 << BIT_W;   // 32 slots per channel

  typedef enum logic [2:0] {
    FMT_LJ      = 3'd0,
    FMT_I2S     = 3'd2,
    FMT_WSYNC   = 3'd4,
    FMT_LSB16   = 3'd5,
    FMT_LSB18   = 3'd6,
    FMT_LSBLAST = 3'd7
  } fmt_e;

  typedef struct packed {
    logic clear;      // port idle: wipe captured state
    logic sideLoad;   // capture inputs at slot 63 start
    logic frameLoad;  // move captures to the sending registers at slot 0
  } aspStrobe_t;
endpackage

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int PHASE_W = 2,
  parameter int CNT_W   = PHASE_W + SLOT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       mode,
  output logic             active,
  output logic             activeQ,
  output logic             repeatEn,
  output fmt_e             fmt,
  output logic [CNT_W-1:0] cnt,
  output aspStrobe_t       st
);
  localparam int CNT_TOP  = (1 << CNT_W) - 1;
  localparam int SIDE_CNT = CNT_TOP - (1 << PHASE_W);

  always_comb begin
    unique case (mode)
      4'd0, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10: active = 1'b1;
      default:                                         active = 1'b0;
    endcase
  end

  assign repeatEn = ~mode[3];
  assign fmt      = fmt_e'(mode[2:0]);

  always_ff @(posedge clk) begin
    if (!rstN || !active) cnt <= '0;
    else                  cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) activeQ <= 1'b0;
    else       activeQ <= active;
  end

  assign st.clear     = ~active;
  assign st.sideLoad  = active && (cnt == CNT_W'(SIDE_CNT));
  assign st.frameLoad = active && (cnt == CNT_W'(CNT_TOP));

  AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    st.frameLoad |=> (cnt == '0)); // R7
  AST_SIDE_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    st.sideLoad && active |=> !st.frameLoad); // R7
endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16,
  parameter int MID_W   = 18,
  parameter int PHASE_W = 2,
  parameter int CNT_W   = PHASE_W + SLOT_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  aspStrobe_t             st,
  input  fmt_e                   fmt,
  input  logic                   repeatEn,
  input  logic                   active,
  input  logic                   activeQ,
  input  logic [CNT_W-1:0]       cnt,
  input  logic [1:0][WORD_W-1:0] inWord,
  input  logic [1:0]             inErr,
  input  logic [1:0]             inValid,
  input  logic [1:0]             inC,
  input  logic [1:0]             inU,
  input  logic                   lockOk,
  input  logic                   cblIn,
  output logic                   sckO,
  output logic                   fsyncO,
  output logic                   sdataO,
  output logic                   cO,
  output logic                   uO,
  output logic                   cblO,
  output logic                   erfO,
  output logic                   verfO
);
  localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] WORD_LIM = BIT_W'(WORD_W);
  localparam logic [BIT_W-1:0] LEAD_S   = BIT_W'(CH_SLOTS - SHORT_W);
  localparam logic [BIT_W-1:0] LEAD_M   = BIT_W'(CH_SLOTS - MID_W);
  localparam logic [BIT_W-1:0] LEAD_L   = BIT_W'(CH_SLOTS - WORD_W);

  logic [1:0][WORD_W-1:0] stWord, curWord, lastGood;
  logic [1:0] stBad, stValid, stC, stU;
  logic [1:0] curBad, curValid, curC, curU;
  logic       stCbl, curCbl;

  always_ff @(posedge clk) begin
    if (!rstN || st.clear) begin
      stWord <= '0; curWord <= '0; lastGood <= '0;
      stBad <= '0; stValid <= '0; stC <= '0; stU <= '0;
      curBad <= '0; curValid <= '0; curC <= '0; curU <= '0;
      stCbl <= 1'b0; curCbl <= 1'b0;
    end else begin
      if (st.sideLoad) begin
        stWord  <= inWord;
        stBad   <= inErr | {2{~lockOk}};
        stValid <= inValid;
        stC     <= inC;
        stU     <= inU;
        stCbl   <= cblIn;
      end
      if (st.frameLoad) begin
        for (int ch = 0; ch < 2; ch++) begin
          curWord[ch] <= (stBad[ch] && repeatEn) ? lastGood[ch] : stWord[ch];
          if (!stBad[ch]) lastGood[ch] <= stWord[ch];
        end
        curBad   <= stBad;
        curValid <= stValid;
        curC     <= stC;
        curU     <= stU;
        curCbl   <= stCbl;
      end
    end
  end

  logic [SLOT_W-1:0] slot, slotI2s;
  logic              chNow, chI2s, selCh, selOk, fsyncD, sideStage, sideCh;
  logic [BIT_W-1:0]  bitNow, bitI2s, sel;

  always_comb begin
    slot    = cnt[CNT_W-1:PHASE_W];
    chNow   = slot[SLOT_W-1];
    bitNow  = slot[BIT_W-1:0];
    slotI2s = slot - SLOT_W'(1);
    chI2s   = slotI2s[SLOT_W-1];
    bitI2s  = slotI2s[BIT_W-1:0];
    selCh   = chNow;
    fsyncD  = ~chNow;
    selOk   = bitNow < WORD_LIM;
    sel     = TOP_BIT - bitNow;
    unique case (fmt)
      FMT_I2S: begin
        fsyncD = chNow;
        selCh  = chI2s;
        selOk  = bitI2s < WORD_LIM;
        sel    = TOP_BIT - bitI2s;
      end
      FMT_WSYNC: fsyncD = (bitNow == '0);
      FMT_LSB16: begin
        selOk = bitNow >= LEAD_S;
        sel   = TOP_BIT - (bitNow - LEAD_S);
      end
      FMT_LSB18: begin
        selOk = bitNow >= LEAD_M;
        sel   = TOP_BIT - (bitNow - LEAD_M);
      end
      FMT_LSBLAST: begin
        selOk = bitNow >= LEAD_L;
        sel   = bitNow - LEAD_L;
      end
      default: ;
    endcase
    // side bits: early handoff except in I2S framing
    sideStage = (fmt != FMT_I2S) && (slot == '1);
    if (fmt == FMT_I2S) sideCh = chNow;
    else                sideCh = (bitNow == '1) ? ~chNow : chNow;
  end

  assign sckO   = active & cnt[PHASE_W-1];
  assign fsyncO = active & fsyncD;
  assign sdataO = active & selOk & curWord[selCh][sel];
  assign cO     = active & (sideStage ? stC[0] : curC[sideCh]);
  assign uO     = active & (sideStage ? stU[0] : curU[sideCh]);
  assign cblO   = active & (sideStage ? stCbl  : curCbl);
  assign erfO   = active & curBad[chNow];
  assign verfO  = active & (curBad[chNow] | curValid[chNow]);

  AST_SDATA_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (active && activeQ && $stable(fmt) && cnt[PHASE_W-1:0] != '0) |-> $stable(sdataO)); // R1
  AST_FLAGS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (active && activeQ && $stable(fmt) && cnt[CNT_W-2:0] != '0) |-> ($stable(erfO) && $stable(verfO))); // R10

  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_REPEAT_LAST_GOOD: assert property (@(posedge clk) disable iff (!rstN)
      (st.frameLoad && repeatEn && stBad[g]) |=> (curWord[g] == $past(lastGood[g]))); // R8
    AST_PASS_DAMAGED: assert property (@(posedge clk) disable iff (!rstN)
      (st.frameLoad && !repeatEn) |=> (curWord[g] == $past(stWord[g]))); // R9
  end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16,
  parameter int MID_W   = 18,
  parameter int PHASE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        mode,
  input  logic [WORD_W-1:0] wordL,
  input  logic [WORD_W-1:0] wordR,
  input  logic              errL,
  input  logic              errR,
  input  logic              lockOk,
  input  logic              validL,
  input  logic              validR,
  input  logic              cL,
  input  logic              cR,
  input  logic              uL,
  input  logic              uR,
  input  logic              cblIn,
  output logic              sckO,
  output logic              fsyncO,
  output logic              sdataO,
  output logic              cO,
  output logic              uO,
  output logic              cblO,
  output logic              erfO,
  output logic              verfO
);
  localparam int CNT_W = PHASE_W + SLOT_W;

  logic             active, activeQ, repeatEn;
  fmt_e             fmt;
  logic [CNT_W-1:0] cnt;
  aspStrobe_t       st;

  asp_ctrl #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .active(active), .activeQ(activeQ),
    .repeatEn(repeatEn), .fmt(fmt), .cnt(cnt), .st(st)
  );

  asp_datapath #(
    .WORD_W(WORD_W), .SHORT_W(SHORT_W), .MID_W(MID_W),
    .PHASE_W(PHASE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .fmt(fmt), .repeatEn(repeatEn),
    .active(active), .activeQ(activeQ), .cnt(cnt),
    .inWord({wordR, wordL}), .inErr({errR, errL}), .inValid({validR, validL}),
    .inC({cR, cL}), .inU({uR, uL}), .lockOk(lockOk), .cblIn(cblIn),
    .sckO(sckO), .fsyncO(fsyncO), .sdataO(sdataO), .cO(cO), .uO(uO),
    .cblO(cblO), .erfO(erfO), .verfO(verfO)
  );

  AST_IDLE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'hF) |-> !(sckO || fsyncO || sdataO || cO || uO || cblO || erfO || verfO)); // R12
endmodule

// File: tb/audio_serial_port_tb.sv
`timescale 1ns/1ps
module audio_serial_port_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] mode = 4'hF;
  logic [23:0] wordL = '0, wordR = '0;
  logic errL = 0, errR = 0, lockOk = 1, validL = 0, validR = 0;
  logic cL = 0, cR = 0, uL = 0, uR = 0, cblIn = 0;
  logic sckO, fsyncO, sdataO, cO, uO, cblO, erfO, verfO;

  always #2 clk = ~clk; // 250 MHz

  audio_serial_port u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .wordL(wordL), .wordR(wordR),
    .errL(errL), .errR(errR), .lockOk(lockOk), .validL(validL), .validR(validR),
    .cL(cL), .cR(cR), .uL(uL), .uR(uR), .cblIn(cblIn),
    .sckO(sckO), .fsyncO(fsyncO), .sdataO(sdataO), .cO(cO), .uO(uO),
    .cblO(cblO), .erfO(erfO), .verfO(verfO)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state
  int rc = 0;
  logic [23:0] sW[2], cW[2], lg[2];
  bit sBad[2], sVal[2], sC[2], sU[2], sCbl;
  bit cBad[2], cVal[2], cC[2], cU[2], cCbl;

  function automatic bit modeActive(input logic [3:0] m);
    return (m == 0 || m == 2 || m == 4 || m == 5 || m == 6 || m == 7 || m == 8 || m == 10);
  endfunction

  function automatic string fmtTag(input logic [3:0] m);
    case (m % 8)
      0: return "R2";
      2: return "R3";
      4: return "R4";
      5, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit got, input bit exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b rc=%0d mode=%0d t=%0t", tag, what, got, exp, rc, mode, $time);
    end
  endtask

  task automatic clearModel();
    for (int k = 0; k < 2; k++) begin
      sW[k] = '0; cW[k] = '0; lg[k] = '0;
      sBad[k] = 0; sVal[k] = 0; sC[k] = 0; sU[k] = 0;
      cBad[k] = 0; cVal[k] = 0; cC[k] = 0; cU[k] = 0;
    end
    sCbl = 0; cCbl = 0;
  endtask

  task automatic compareAll();
    int slot, ph, ch, b, f, d, dc, db, wb;
    bit eSck, eFs, eSd, eC, eU, eCbl, eErf, eVerf, act;
    string tF, tD;
    slot = rc / 4; ph = rc % 4; ch = slot / 32; b = slot % 32;
    f = mode % 8; act = modeActive(mode);
    dc = ch; eSd = 0; eFs = !ch;
    case (f)
      2: begin
        eFs = ch; d = (slot + 63) % 64; dc = d / 32; db = d % 32;
        if (db < 24) eSd = cW[dc][23 - db];
      end
      4: begin eFs = (b == 0); if (b < 24) eSd = cW[ch][23 - b]; end
      5: if (b >= 16) begin wb = 23 - (b - 16); eSd = cW[ch][wb]; end
      6: if (b >= 14) begin wb = 23 - (b - 14); eSd = cW[ch][wb]; end
      7: if (b >= 8) eSd = cW[ch][b - 8];
      default: if (b < 24) eSd = cW[ch][23 - b];
    endcase
    if (f == 2) begin eC = cC[ch]; eU = cU[ch]; eCbl = cCbl; end
    else if (slot == 63) begin eC = sC[0]; eU = sU[0]; eCbl = sCbl; end
    else if (slot >= 31) begin eC = cC[1]; eU = cU[1]; eCbl = cCbl; end
    else begin eC = cC[0]; eU = cU[0]; eCbl = cCbl; end
    eSck = (ph >= 2); eErf = cBad[ch]; eVerf = cBad[ch] | cVal[ch];
    tF = fmtTag(mode);
    tD = cBad[dc] ? (mode[3] ? "R9" : "R8") : {"R7/", tF};
    if (!act) begin
      chk(sckO, 0, "R12", "sck");  chk(fsyncO, 0, "R12", "fsync");
      chk(sdataO, 0, "R12", "sdata"); chk(cO, 0, "R12", "c");
      chk(uO, 0, "R12", "u");      chk(cblO, 0, "R12", "cbl");
      chk(erfO, 0, "R12", "erf");  chk(verfO, 0, "R12", "verf");
    end else begin
      chk(sckO, eSck, "R1", "sck");
      chk(fsyncO, eFs, tF, "fsync");
      chk(sdataO, eSd, tD, "sdata");
      chk(cO, eC, "R11", "c"); chk(uO, eU, "R11", "u"); chk(cblO, eCbl, "R11", "cbl");
      chk(erfO, eErf, "R10", "erf"); chk(verfO, eVerf, "R10", "verf");
    end
  endtask

  // reference model advances on each edge, compared just after it
  always @(posedge clk) begin
    if (!rstN || !modeActive(mode)) begin
      clearModel(); rc = 0;
    end else begin
      if (rc == 251) begin
        sW[0] = wordL; sW[1] = wordR;
        sBad[0] = errL | !lockOk; sBad[1] = errR | !lockOk;
        sVal[0] = validL; sVal[1] = validR;
        sC[0] = cL; sC[1] = cR; sU[0] = uL; sU[1] = uR; sCbl = cblIn;
      end
      if (rc == 255) begin
        for (int k = 0; k < 2; k++) begin
          cW[k] = (sBad[k] && !mode[3]) ? lg[k] : sW[k];
          if (!sBad[k]) lg[k] = sW[k];
          cBad[k] = sBad[k]; cVal[k] = sVal[k]; cC[k] = sC[k]; cU[k] = sU[k];
        end
        cCbl = sCbl;
      end
      rc = (rc + 1) % 256;
    end
    #1;
    if (!finished) compareAll();
  end

  task automatic driveInputs(input bit withErr);
    wordL = 24'($urandom); wordR = 24'($urandom);
    validL = ($urandom % 5 == 0); validR = ($urandom % 5 == 0);
    cL = $urandom % 2; cR = $urandom % 2; uL = $urandom % 2; uR = $urandom % 2;
    cblIn = $urandom % 2;
    errL = withErr && ($urandom % 3 == 0);
    errR = withErr && ($urandom % 3 == 0);
    lockOk = !(withErr && ($urandom % 5 == 0));
  endtask

  task automatic runFrames(input int n, input bit withErr);
    for (int i = 0; i < n * 256; i++) begin
      @(negedge clk);
      if (rc == 40 || (!modeActive(mode) && i % 97 == 0)) driveInputs(withErr);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [3:0] actList[8] = '{4'd0, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10};
    logic [3:0] idleList[7] = '{4'd1, 4'd3, 4'd9, 4'd11, 4'd12, 4'd13, 4'd14};
    repeat (8) @(negedge clk);
    rstN = 1;
    repeat (16) @(negedge clk);
    foreach (actList[i]) begin
      mode = 4'hF;
      repeat (6) @(negedge clk);
      mode = actList[i];
      runFrames(3, 0);
      runFrames(6, 1);
    end
    foreach (idleList[i]) begin
      mode = idleList[i];
      runFrames(1, 1);
    end
    mode = 4'd0;
    runFrames(2, 1);
    rstN = 0;
    repeat (20) @(negedge clk);
    rstN = 1;
    runFrames(2, 1);
    finish();
  end
endmodule